// File: doc/BRIEF.md
# Sub-word Register Write Coalescing Bridge

This bridge sits between a host bus that makes 8-, 16- and 32-bit register accesses and a register file that accepts only aligned 32-bit reads and writes. A byte or halfword write becomes a read-modify-write of the containing word: the bridge reads the word, replaces the addressed lane and writes the whole word back.

Halfword writes to the block-size and block-count halfwords (offsets 0x04 and 0x06) and to the transfer-mode halfword (0x0C) are not forwarded. They are held in two 32-bit shadow words, the block shadow and the command shadow. Writing the command halfword (0x0E) releases them as ordered full-word writes: the block shadow first, then the merged command word. Halfword reads of the held registers are answered from the shadows. While the card clock is slow, every downstream write is followed by a guard wait. During that wait the host request port is held not-ready, so two downstream writes never reach the register file closer together than the slow domain can absorb.

The host request port is valid/ready. A request transfers on a clock edge where `hreq_valid` and `hreq_ready` are both high. `hreq_ready` is high only while the bridge is idle. Once the request has been accepted, the host may drop `hreq_valid` or change the fields. Each accepted request produces exactly one single-cycle `hrsp_valid` pulse. The response has no back-pressure. The register file's read data must be valid in the same cycle as `dn_rd_en`.

Top module: `subword_wr_bridge`

## Requirements
- R1: Every downstream access uses all 32 bits, at the request address with its two low bits cleared. A read strobe and a write strobe are never active together.
- R2: A byte or halfword write outside the held registers reads the containing word, then writes it back with only the addressed lane replaced. The lane starts at bit 8*addr[1:0], and its mask is 0xFF for a byte or 0xFFFF for a halfword.
- R3: A halfword write to 0x04 or 0x06 makes no downstream write. It merges into the block shadow and marks that shadow valid. The merge starts from the block shadow if it is already valid, and otherwise from a downstream read of word 0x04.
- R4: A halfword write to 0x0C makes no downstream write. It merges into the downstream word 0x0C and stores the result in the command shadow, which it marks valid.
- R5: A halfword write to 0x0E first writes the block shadow to word 0x04, if that shadow is valid. It then writes the command shadow, with its upper lane replaced, to word 0x0C. Both valid marks are cleared.
- R6: A halfword read of 0x0C returns the command shadow's low lane while that shadow is valid. A halfword read of 0x04 or 0x06 returns the matching lane of the block shadow while that shadow is valid. Every other read, including every byte and word read, returns the downstream word's lane, right-aligned.
- R7: Each downstream write is followed by a wait, during which no new request is accepted. The wait is ceil(4000/card_khz) microseconds when card_khz is 1 to 400, and 10 µs when card_khz is 0. It is counted as CYC_PER_US cycles per microsecond, so two writes are spaced by exactly the wait plus one cycle. Above 400 kHz there is no wait, and the two writes of a command release land on adjacent cycles.
- R8: A full-word write passes straight to the register file and leaves both shadows and their valid marks unchanged.
- R9: After reset both shadows are invalid, so halfword reads of 0x04, 0x06 and 0x0C return downstream data. After reset `hreq_ready` is high and `hrsp_valid` is low.
- R10: Each accepted request gives exactly one single-cycle `hrsp_valid` pulse. For a read, `hrsp_rdata` is valid with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Bridge ready to accept a request |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| hreq_addr | input | AW | Host byte address |
| hreq_wdata | input | 32 | Write data, right-aligned for sub-word writes |
| hrsp_valid | output | 1 | Response pulse, one per request |
| hrsp_rdata | output | 32 | Read data, right-aligned lane |
| card_khz | input | KHZ_W | Card clock frequency in kHz |
| dn_rd_en | output | 1 | Register file read strobe |
| dn_wr_en | output | 1 | Register file write strobe |
| dn_addr | output | AW | Register file word address, low bits zero |
| dn_wdata | output | 32 | Register file write data |
| dn_rdata | input | 32 | Register file read data, valid with dn_rd_en |

## Verification
The assertions assume that sub-word requests are naturally aligned, meaning halfword addresses are even and word addresses have both low bits clear. They also assume that `card_khz` stays constant while a request is being served. The bench draws random sizes, read/write choices and addresses, but aligns each address to its size and heavily weights the four held offsets. It changes the card frequency only between requests, while the bridge is idle.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EXEC,
    S_WBLK,
    S_WR,
    S_GUARD,
    S_RESP
  } bridge_state_e;

  localparam logic [7:0] OFF_BLK_SIZE  = 8'h04;
  localparam logic [7:0] OFF_BLK_COUNT = 8'h06;
  localparam logic [7:0] OFF_XFER_MODE = 8'h0C;
  localparam logic [7:0] OFF_COMMAND   = 8'h0E;

  localparam int SLOW_KHZ_LIMIT = 400;
  localparam int GUARD_KHZ_US   = 4000;
  localparam int STOPPED_US     = 10;
endpackage

// File: rtl/sbw_lane_unit.sv
module sbw_lane_unit
  import sbw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] wdata,
  input  acc_size_e     size,
  input  logic [1:0]    lane,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] extracted
);
  logic [4:0]    shift;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] place_mask;

  always_comb begin
    unique case (size)
      SZ_BYTE: lane_mask = DW'(32'h0000_00FF);
      SZ_HALF: lane_mask = DW'(32'h0000_FFFF);
      default: lane_mask = '1;
    endcase
    shift      = (size == SZ_WORD) ? 5'd0 : {lane, 3'b000};
    place_mask = lane_mask << shift;
    merged     = (base & ~place_mask) | ((wdata & lane_mask) << shift);
    extracted  = (base >> shift) & lane_mask;
  end
endmodule

// File: rtl/sbw_guard_timer.sv
module sbw_guard_timer
  import sbw_pkg::*;
#(
  parameter int CYC_PER_US = 200,
  parameter int KHZ_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KHZ_W-1:0] card_khz,
  output logic             needed,
  output logic             busy,
  output logic             last
);
  localparam int CNT_W = $clog2(GUARD_KHZ_US * CYC_PER_US + 1);

  logic [12:0]      wait_us;
  logic [31:0]      wait_prod;
  logic [CNT_W-1:0] wait_cyc;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (card_khz == '0)
      wait_us = 13'(STOPPED_US);
    else if (card_khz <= KHZ_W'(SLOW_KHZ_LIMIT))
      wait_us = (13'(GUARD_KHZ_US) + 13'(card_khz) - 13'd1) / 13'(card_khz);
    else
      wait_us = '0;
    wait_prod = {19'd0, wait_us} * 32'(CYC_PER_US);
    wait_cyc  = wait_prod[CNT_W-1:0];
  end

  assign needed = (wait_us != '0);
  assign busy   = (cnt != '0);
  assign last   = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start && needed)
      cnt <= wait_cyc;
    else if (busy)
      cnt <= cnt - CNT_W'(1);
  end

  // R7: no downstream write may begin while a guard wait is still running
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  // R7: a loaded guard counts down by one each cycle
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/subword_wr_bridge.sv
module subword_wr_bridge
  import sbw_pkg::*;
#(
  parameter int AW         = 8,
  parameter int KHZ_W      = 20,
  parameter int CYC_PER_US = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hreq_valid,
  output logic             hreq_ready,
  input  logic             hreq_write,
  input  logic [1:0]       hreq_size,
  input  logic [AW-1:0]    hreq_addr,
  input  logic [31:0]      hreq_wdata,
  output logic             hrsp_valid,
  output logic [31:0]      hrsp_rdata,
  input  logic [KHZ_W-1:0] card_khz,
  output logic             dn_rd_en,
  output logic             dn_wr_en,
  output logic [AW-1:0]    dn_addr,
  output logic [31:0]      dn_wdata,
  input  logic [31:0]      dn_rdata
);
  localparam logic [AW-1:0] A_BLK_SIZE  = AW'(OFF_BLK_SIZE);
  localparam logic [AW-1:0] A_BLK_COUNT = AW'(OFF_BLK_COUNT);
  localparam logic [AW-1:0] A_XFER_MODE = AW'(OFF_XFER_MODE);
  localparam logic [AW-1:0] A_COMMAND   = AW'(OFF_COMMAND);

  bridge_state_e state, state_nx;

  logic            req_wr;
  acc_size_e       req_size;
  logic [AW-1:0]   req_addr;
  logic [31:0]     req_wdata;
  logic [31:0]     blk_sh, cmd_sh, wr_word, rsp_data;
  logic            blk_v, cmd_v, resume_wr;

  logic            is_half, hit_blk, hit_xfer, hit_cmd;
  logic            use_blk, use_cmd;
  logic [31:0]     base_word, merged, extracted;
  logic            g_start, g_needed, g_busy, g_last;
  logic [AW-1:0]   req_word_addr;

  // ---- request decode ------------------------------------------------
  assign is_half       = (req_size == SZ_HALF);
  assign hit_blk       = is_half && (req_addr == A_BLK_SIZE || req_addr == A_BLK_COUNT);
  assign hit_xfer      = is_half && (req_addr == A_XFER_MODE);
  assign hit_cmd       = is_half && (req_addr == A_COMMAND);
  assign req_word_addr = {req_addr[AW-1:2], 2'b00};

  always_comb begin
    use_blk = hit_blk && blk_v;
    use_cmd = req_wr ? hit_cmd : (hit_xfer && cmd_v);
    if (use_cmd)      base_word = cmd_sh;
    else if (use_blk) base_word = blk_sh;
    else              base_word = dn_rdata;
  end

  sbw_lane_unit #(.DW(32)) u_lane (
    .base      (base_word),
    .wdata     (req_wdata),
    .size      (req_size),
    .lane      (req_addr[1:0]),
    .merged    (merged),
    .extracted (extracted)
  );

  sbw_guard_timer #(.CYC_PER_US(CYC_PER_US), .KHZ_W(KHZ_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (g_start),
    .card_khz (card_khz),
    .needed   (g_needed),
    .busy     (g_busy),
    .last     (g_last)
  );

  // ---- downstream port ------------------------------------------------
  always_comb begin
    dn_rd_en = 1'b0;
    if (state == S_EXEC && !use_blk && !use_cmd)
      dn_rd_en = !(req_wr && req_size == SZ_WORD);
  end

  assign dn_wr_en   = (state == S_WBLK) || (state == S_WR);
  assign dn_addr    = (state == S_WBLK) ? A_BLK_SIZE : req_word_addr;
  assign dn_wdata   = (state == S_WBLK) ? blk_sh : wr_word;
  assign g_start    = dn_wr_en;
  assign hreq_ready = (state == S_IDLE);
  assign hrsp_valid = (state == S_RESP);
  assign hrsp_rdata = rsp_data;

  // ---- sequencing -----------------------------------------------------
  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (hreq_valid) state_nx = S_EXEC;
      S_EXEC: begin
        if (!req_wr || hit_blk || hit_xfer) state_nx = S_RESP;
        else if (hit_cmd && blk_v)          state_nx = S_WBLK;
        else                                state_nx = S_WR;
      end
      S_WBLK:  state_nx = g_needed ? S_GUARD : S_WR;
      S_WR:    state_nx = g_needed ? S_GUARD : S_RESP;
      S_GUARD: if (g_last) state_nx = resume_wr ? S_WR : S_RESP;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      req_wr    <= 1'b0;
      req_size  <= SZ_BYTE;
      req_addr  <= '0;
      req_wdata <= '0;
      blk_sh    <= '0;
      cmd_sh    <= '0;
      blk_v     <= 1'b0;
      cmd_v     <= 1'b0;
      wr_word   <= '0;
      rsp_data  <= '0;
      resume_wr <= 1'b0;
    end else begin
      state <= state_nx;
      unique case (state)
        S_IDLE: if (hreq_valid) begin
          req_wr    <= hreq_write;
          req_size  <= acc_size_e'(hreq_size);
          req_addr  <= hreq_addr;
          req_wdata <= hreq_wdata;
        end
        S_EXEC: begin
          if (!req_wr) begin
            rsp_data <= extracted;
          end else if (hit_blk) begin
            blk_sh <= merged;
            blk_v  <= 1'b1;
          end else if (hit_xfer) begin
            cmd_sh <= merged;
            cmd_v  <= 1'b1;
          end else begin
            wr_word <= merged;
            if (hit_cmd) cmd_v <= 1'b0;
          end
        end
        S_WBLK: begin
          blk_v     <= 1'b0;
          resume_wr <= g_needed;
        end
        S_GUARD: if (g_last) resume_wr <= 1'b0;
        default: ;
      endcase
    end
  end

  // R1: downstream accesses are whole aligned words
  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd_en || dn_wr_en) |-> (dn_addr[1:0] == 2'b00));
  // R1: one downstream access per cycle
  p_one_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_rd_en && dn_wr_en));
  // R5: the command word never overtakes a held block word
  p_blk_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && hit_cmd) |-> !blk_v);
  // R8: a full-word write leaves both shadows alone
  p_word_keeps_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && req_wr && req_size == SZ_WORD)
      |=> ($stable(blk_sh) && $stable(cmd_sh) && $stable(blk_v) && $stable(cmd_v)));
  // R10: responses are single-cycle pulses
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid |=> !hrsp_valid);
  // R7: nothing is accepted while a guard wait runs
  p_guard_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    g_busy |-> !hreq_ready);
endmodule

// File: tb/subword_wr_bridge_test.sv
module subword_wr_bridge_test;
  localparam int AW  = 8;
  localparam int KW  = 20;
  localparam int CPU = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hreq_valid = 1'b0, hreq_write = 1'b0;
  logic [1:0]    hreq_size = 2'd0;
  logic [AW-1:0] hreq_addr = '0;
  logic [31:0]   hreq_wdata = '0;
  logic          hreq_ready, hrsp_valid;
  logic [31:0]   hrsp_rdata;
  logic [KW-1:0] card_khz = KW'(25000);
  logic          dn_rd_en, dn_wr_en;
  logic [AW-1:0] dn_addr;
  logic [31:0]   dn_wdata, dn_rdata;

  int tests = 0, fails = 0;
  logic [31:0] mem [0:63];
  longint cyc = 0, last_cyc = 0;
  int last_g = 0;
  bit have_last = 0;
  int obs_n = 0;
  logic [AW-1:0] obs_addr [0:3];
  logic [31:0]   obs_data [0:3];
  longint        obs_cyc  [0:3];

  logic [31:0] m_bsh = 0, m_csh = 0;
  bit m_bv = 0, m_cv = 0;

  always #2.5 clk = ~clk;

  subword_wr_bridge #(.AW(AW), .KHZ_W(KW), .CYC_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .hreq_valid(hreq_valid), .hreq_ready(hreq_ready),
    .hreq_write(hreq_write), .hreq_size(hreq_size), .hreq_addr(hreq_addr),
    .hreq_wdata(hreq_wdata), .hrsp_valid(hrsp_valid), .hrsp_rdata(hrsp_rdata),
    .card_khz(card_khz), .dn_rd_en(dn_rd_en), .dn_wr_en(dn_wr_en),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata));

  assign dn_rdata = mem[dn_addr[7:2]];

  function automatic int gcyc(input int khz);
    if (khz == 0) return 10 * CPU;
    if (khz <= 400) return ((4000 + khz - 1) / khz) * CPU;
    return 0;
  endfunction

  function automatic logic [31:0] lmask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] b, input logic [31:0] w,
                                      input logic [1:0] sz, input logic [7:0] a);
    int sh = (sz == 2'd2) ? 0 : a[1:0] * 8;
    return (b & ~(lmask(sz) << sh)) | ((w & lmask(sz)) << sh);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // register file and guard spacing monitor (R7)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dn_wr_en) begin
      mem[dn_addr[7:2]] <= dn_wdata;
      if (obs_n < 4) begin
        obs_addr[obs_n] <= dn_addr;
        obs_data[obs_n] <= dn_wdata;
        obs_cyc[obs_n]  <= cyc;
      end
      obs_n <= obs_n + 1;
      if (have_last) chk((cyc - last_cyc) >= longint'(last_g + 1), "R7 spacing",
                         64'(cyc - last_cyc), 64'(last_g + 1));
      have_last <= 1;
      last_cyc  <= cyc;
      last_g    <= gcyc(int'(card_khz));
    end
  end

  task automatic host_op(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                         input logic [31:0] wd, input string tag);
    logic [7:0]  wa = {a[7:2], 2'b00};
    int          sh = (sz == 2'd2) ? 0 : a[1:0] * 8;
    bit half = (sz == 2'd1);
    bit hb = half && (a == 8'h04 || a == 8'h06);
    bit hx = half && a == 8'h0C;
    bit hc = half && a == 8'h0E;
    int en = 0;
    logic [7:0]  ea [0:1];
    logic [31:0] ed [0:1];
    logic [31:0] base, er = 0;
    int gap = gcyc(int'(card_khz)) + 1;
    if (!wr) begin
      base = (hx && m_cv) ? m_csh : (hb && m_bv) ? m_bsh : mem[wa[7:2]];
      er = (base >> sh) & lmask(sz);
    end else if (sz == 2'd2) begin
      ea[0] = wa; ed[0] = wd; en = 1;
    end else if (hb) begin
      m_bsh = mrg(m_bv ? m_bsh : mem[1], wd, sz, a); m_bv = 1;
    end else if (hx) begin
      m_csh = mrg(mem[3], wd, sz, a); m_cv = 1;
    end else if (hc) begin
      if (m_bv) begin ea[en] = 8'h04; ed[en] = m_bsh; en++; m_bv = 0; end
      ea[en] = 8'h0C; ed[en] = mrg(m_csh, wd, sz, a); en++; m_cv = 0;
    end else begin
      ea[0] = wa; ed[0] = mrg(mem[wa[7:2]], wd, sz, a); en = 1;
    end
    @(negedge clk);
    while (!hreq_ready) @(negedge clk);
    obs_n = 0;
    hreq_valid = 1; hreq_write = wr; hreq_size = sz; hreq_addr = a; hreq_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    hreq_valid = 0;
    while (!hrsp_valid) @(negedge clk);
    @(negedge clk);
    chk(!hrsp_valid, {tag, " R10 pulse"}, 64'(hrsp_valid), 64'd0);
    chk(obs_n == en, {tag, " write count"}, 64'(obs_n), 64'(en));
    for (int i = 0; i < en && i < obs_n; i++) begin
      chk(obs_addr[i] == ea[i], {tag, " R1 addr"}, 64'(obs_addr[i]), 64'(ea[i]));
      chk(obs_data[i] == ed[i], {tag, " data"}, 64'(obs_data[i]), 64'(ed[i]));
    end
    if (en == 2 && obs_n == 2)
      chk(obs_cyc[1] - obs_cyc[0] == longint'(gap), {tag, " R7 pair gap"},
          64'(obs_cyc[1] - obs_cyc[0]), 64'(gap));
    if (!wr) chk(hrsp_rdata == er, {tag, " R6 rdata"}, 64'(hrsp_rdata), 64'(er));
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(hreq_ready == 1'b1, "R9 ready after reset", 64'(hreq_ready), 64'd1);
    chk(hrsp_valid == 1'b0, "R9 no response in reset", 64'(hrsp_valid), 64'd0);
    rst_n = 1;
    // R9: shadows empty after reset
    host_op(0, 2'd1, 8'h06, 0, "R9 read blk count");
    host_op(0, 2'd1, 8'h0C, 0, "R9 read xfer");
    // R2: read-modify-write of plain registers
    host_op(1, 2'd0, 8'h23, 32'hA5, "R2 byte");
    host_op(1, 2'd1, 8'h12, 32'h1234, "R2 half");
    // R3 / R6: block shadow
    host_op(1, 2'd1, 8'h06, 32'hBEEF, "R3 blk count");
    host_op(1, 2'd1, 8'h04, 32'h0200, "R3 blk size");
    host_op(0, 2'd1, 8'h06, 0, "R6 blk shadow read");
    host_op(0, 2'd0, 8'h06, 0, "R6 byte bypasses shadow");
    // R4 / R6: command shadow
    host_op(1, 2'd1, 8'h0C, 32'h0033, "R4 xfer");
    host_op(0, 2'd1, 8'h0C, 0, "R6 xfer shadow read");
    host_op(0, 2'd2, 8'h0C, 0, "R6 word bypasses shadow");
    // R8: word write passes, shadows kept
    host_op(1, 2'd2, 8'h04, 32'h1111_2222, "R8 word write");
    host_op(0, 2'd1, 8'h04, 0, "R8 shadow kept");
    // R5 / R7: fast release, adjacent writes
    host_op(1, 2'd1, 8'h0E, 32'h0C11, "R5 fast release");
    // R7: slow release at 300 kHz
    card_khz = KW'(300);
    host_op(1, 2'd1, 8'h04, 32'h0040, "R3 slow setup");
    host_op(1, 2'd1, 8'h0E, 32'h1A2B, "R5 R7 slow release");
    card_khz = KW'(0);
    host_op(1, 2'd1, 8'h06, 32'h0007, "R3 stopped setup");
    host_op(1, 2'd1, 8'h0E, 32'h0D00, "R5 R7 stopped release");
    // R7: longest wait at 1 kHz, host held off
    card_khz = KW'(1);
    fork
      host_op(1, 2'd2, 8'h30, 32'hCAFE_F00D, "R7 1kHz word");
      begin
        repeat (200) @(negedge clk);
        chk(hreq_ready == 1'b0, "R7 ready held low", 64'(hreq_ready), 64'd0);
      end
    join
    // random mix
    for (int n = 0; n < 300; n++) begin
      int r = $urandom % 8;
      int k = $urandom % 4;
      logic [1:0] sz = 2'($urandom % 3);
      logic [7:0] a;
      card_khz = (k == 0) ? KW'(400) : (k == 1) ? KW'(350) : KW'(25000);
      if (r < 4) begin
        a = (r == 0) ? 8'h04 : (r == 1) ? 8'h06 : (r == 2) ? 8'h0C : 8'h0E;
        if ($urandom % 2) sz = 2'd1;
      end else a = 8'($urandom);
      if (sz == 2'd1) a[0] = 1'b0;
      if (sz == 2'd2) a[1:0] = 2'b00;
      host_op(($urandom % 10) < 6, sz, a, $urandom, "random R2 R3 R4 R5 R6 R8");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule